// File: doc/BRIEF.md
# Two-Coil Gauge Angle Decoder

This block turns a 10-bit pointer angle into the drive words for the two coils of an air-core pointer gauge. The full turn is split into 1024 steps of roughly 0.35 degrees. The code is read as a 3-bit octant number (45 degrees each) and a 7-bit position inside that octant. In every octant, one coil is held at full scale and the other coil ramps. The octant decides which coil is held, the sign of each coil, and whether the ramping coil is indexed forward or backward.

The coil drive is not a true sine and cosine pair. It is the pair projected onto a square: the larger coil always sits at full scale, and the smaller one is full scale times the tangent of the angle inside the octant. The two coils meet near full scale at the odd multiples of 45 degrees. The signed words go to a DAC and are not used anywhere else. A host writes a code and pulses the load strobe. The outputs change on the next clock edge and then hold.

Top module: `gauge_angle_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, both `sin_drv` and `cos_drv` become 0 after that edge.
- R2: The outputs take their new value on the rising edge where `load` is high. Changes on `code` while `load` is low do not affect the outputs, which hold.
- R3: Bits 9..7 of `code` are the octant and bits 6..0 are the step. In octants 0, 3, 4 and 7 the cosine coil is at full scale, positive in 0 and 7 and negative in 3 and 4. In octants 1, 2, 5 and 6 the sine coil is at full scale, positive in 1 and 2 and negative in 5 and 6.
- R4: Code 0 gives sin 0 and cos +255. Code 256 gives +255 and 0. Code 512 gives 0 and −255. Code 768 gives −255 and 0.
- R5: At codes 128, 384, 640 and 896 both coils have a magnitude of at least 248. The signs (sin, cos) are (+,+), (+,−), (−,−) and (−,+) in that order.
- R6: For any code with angle θ = code·360/1024 degrees, each output is within ±4 of round(255·f(θ)/max(|sin θ|,|cos θ|)), where f is sin or cos. The ramp is indexed by the step in even octants and by its bitwise complement in odd octants.
- R7: Inside octant 0, `sin_drv` does not decrease as the step rises from 0 to 127.
- R8: The outputs are 9-bit two's complement words in the range −255 to +255. After any load, at least one coil is exactly ±255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Strobe: register the drive for `code` |
| code | input | 10 | Pointer angle, 1024 steps per turn |
| sin_drv | output | 9 | Signed sine-coil drive word |
| cos_drv | output | 9 | Signed cosine-coil drive word |

## Verification
The four cardinal codes confirm that the ramp is zero at the start of even octants and that each full-scale coil has the correct sign. The four diagonal codes test the complemented index of the odd octants and the point where both coils meet. A mid-octant code in each of the eight octants shows whether the octant decode chooses the right held coil and sign. A full sweep of all 1024 codes against a square-projected trigonometric model catches errors in the ramp table and in the index fold. A hold pattern, where the code changes while the strobe stays low, shows whether the output register is correctly gated.

// File: rtl/gauge_angle_pkg.sv
package gauge_angle_pkg;

    localparam int OCT_W = 3;

    typedef struct packed {
        logic sat_on_sin;
        logic sat_neg;
        logic ramp_neg;
    } oct_ctrl_t;

    function automatic oct_ctrl_t octant_ctrl(input logic [OCT_W-1:0] oct);
        oct_ctrl_t c;
        case (oct)
            3'd0:    c = '{sat_on_sin: 1'b0, sat_neg: 1'b0, ramp_neg: 1'b0};
            3'd1:    c = '{sat_on_sin: 1'b1, sat_neg: 1'b0, ramp_neg: 1'b0};
            3'd2:    c = '{sat_on_sin: 1'b1, sat_neg: 1'b0, ramp_neg: 1'b1};
            3'd3:    c = '{sat_on_sin: 1'b0, sat_neg: 1'b1, ramp_neg: 1'b0};
            3'd4:    c = '{sat_on_sin: 1'b0, sat_neg: 1'b1, ramp_neg: 1'b1};
            3'd5:    c = '{sat_on_sin: 1'b1, sat_neg: 1'b1, ramp_neg: 1'b1};
            3'd6:    c = '{sat_on_sin: 1'b1, sat_neg: 1'b1, ramp_neg: 1'b0};
            default: c = '{sat_on_sin: 1'b0, sat_neg: 1'b0, ramp_neg: 1'b1};
        endcase
        return c;
    endfunction

    // Q16 odd polynomial for tan(pi/4 * t), t in [0,1], forced to 1 at t = 1
    localparam longint TAN_A = 51472;
    localparam longint TAN_B = 10584;
    localparam longint TAN_C = 2628;
    localparam longint TAN_D = 65536 - TAN_A - TAN_B - TAN_C;

    function automatic int ramp_mag(input int step, input int frac_w, input int full);
        longint x, x2, p, r;
        x  = (longint'(step) <<< 16) >>> frac_w;
        x2 = (x * x) >>> 16;
        p  = TAN_D;
        p  = TAN_C + ((p * x2) >>> 16);
        p  = TAN_B + ((p * x2) >>> 16);
        p  = TAN_A + ((p * x2) >>> 16);
        r  = (p * x) >>> 16;
        return int'((r * longint'(full) + 32768) >>> 16);
    endfunction

endpackage

// File: rtl/gad_splitter.sv
module gad_splitter
    import gauge_angle_pkg::*;
#(
    parameter int CODE_W = 10,
    localparam int FRAC_W = CODE_W - OCT_W
) (
    input  logic [CODE_W-1:0] code,
    output oct_ctrl_t         ctrl,
    output logic [FRAC_W-1:0] lut_idx
);
    logic [OCT_W-1:0]  octant;
    logic [FRAC_W-1:0] step;

    assign octant  = code[CODE_W-1 -: OCT_W];
    assign step    = code[FRAC_W-1:0];
    assign ctrl    = octant_ctrl(octant);
    // odd octants run the ramp backward
    assign lut_idx = octant[0] ? ~step : step;
endmodule

// File: rtl/gad_ramp_lut.sv
module gad_ramp_lut
    import gauge_angle_pkg::*;
#(
    parameter int FRAC_W = 7,
    parameter int MAG_W  = 8,
    localparam int DEPTH = 2 ** FRAC_W,
    localparam int FULL  = 2 ** MAG_W - 1
) (
    input  logic [FRAC_W-1:0] idx,
    output logic [MAG_W-1:0]  mag
);
    logic [MAG_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int VAL = ramp_mag(i, FRAC_W, FULL);
        assign table_q[i] = MAG_W'(VAL);
    end

    assign mag = table_q[idx];
endmodule

// File: rtl/gad_coil_mux.sv
module gad_coil_mux
    import gauge_angle_pkg::*;
#(
    parameter int OUT_W = 9,
    localparam int MAG_W = OUT_W - 1
) (
    input  oct_ctrl_t                ctrl,
    input  logic [MAG_W-1:0]         ramp,
    output logic signed [OUT_W-1:0]  sin_nxt,
    output logic signed [OUT_W-1:0]  cos_nxt
);
    localparam logic signed [OUT_W-1:0] FS = OUT_W'(2 ** MAG_W - 1);

    logic signed [OUT_W-1:0] sat_val;
    logic signed [OUT_W-1:0] ramp_pos;
    logic signed [OUT_W-1:0] ramp_val;

    always_comb begin
        ramp_pos = $signed({1'b0, ramp});
        sat_val  = ctrl.sat_neg  ? -FS       : FS;
        ramp_val = ctrl.ramp_neg ? -ramp_pos : ramp_pos;
        if (ctrl.sat_on_sin) begin
            sin_nxt = sat_val;
            cos_nxt = ramp_val;
        end else begin
            sin_nxt = ramp_val;
            cos_nxt = sat_val;
        end
    end
endmodule

// File: rtl/gauge_angle_decoder.sv
module gauge_angle_decoder
    import gauge_angle_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int OUT_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [CODE_W-1:0]        code,
    output logic signed [OUT_W-1:0]  sin_drv,
    output logic signed [OUT_W-1:0]  cos_drv
);
    localparam int FRAC_W = CODE_W - OCT_W;
    localparam int MAG_W  = OUT_W - 1;

    oct_ctrl_t               ctrl;
    logic [FRAC_W-1:0]       lut_idx;
    logic [MAG_W-1:0]        ramp;
    logic signed [OUT_W-1:0] sin_nxt;
    logic signed [OUT_W-1:0] cos_nxt;

    gad_splitter #(.CODE_W(CODE_W)) u_split (
        .code    (code),
        .ctrl    (ctrl),
        .lut_idx (lut_idx)
    );

    gad_ramp_lut #(.FRAC_W(FRAC_W), .MAG_W(MAG_W)) u_lut (
        .idx (lut_idx),
        .mag (ramp)
    );

    gad_coil_mux #(.OUT_W(OUT_W)) u_mux (
        .ctrl    (ctrl),
        .ramp    (ramp),
        .sin_nxt (sin_nxt),
        .cos_nxt (cos_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_drv <= '0;
            cos_drv <= '0;
        end else if (load) begin
            sin_drv <= sin_nxt;
            cos_drv <= cos_nxt;
        end
    end
endmodule

// File: rtl/gauge_angle_decoder_chk.sv
module gauge_angle_decoder_chk #(
    parameter int CODE_W = 10,
    parameter int OUT_W  = 9
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     load,
    input logic [CODE_W-1:0]        code,
    input logic signed [OUT_W-1:0]  sin_drv,
    input logic signed [OUT_W-1:0]  cos_drv
);
    localparam logic signed [OUT_W-1:0] FS  = OUT_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [OUT_W-1:0] NFS = -FS;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (sin_drv == '0 && cos_drv == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(sin_drv) && $stable(cos_drv)));

    assert_octant0_cos_R3: assert property (@(posedge clk) disable iff (rst)
        (load && code[CODE_W-1 -: 3] == 3'd0) |=> (cos_drv == FS && sin_drv >= 0));

    assert_zero_code_R4: assert property (@(posedge clk) disable iff (rst)
        (load && code == '0) |=> (sin_drv == '0 && cos_drv == FS));

    assert_one_full_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (sin_drv == FS || sin_drv == NFS || cos_drv == FS || cos_drv == NFS));

    assert_range_R8: assert property (@(posedge clk) disable iff (rst)
        (sin_drv >= NFS && cos_drv >= NFS));
endmodule

bind gauge_angle_decoder gauge_angle_decoder_chk #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .code    (code),
    .sin_drv (sin_drv),
    .cos_drv (cos_drv)
);

// File: tb/gauge_angle_decoder_bench.sv
`timescale 1ns/1ps
module gauge_angle_decoder_bench;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load = 1'b0;
    logic [9:0]        code = '0;
    logic signed [8:0] sin_drv;
    logic signed [8:0] cos_drv;
    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    gauge_angle_decoder u_gauge_angle_decoder (
        .clk(clk), .rst(rst), .load(load), .code(code),
        .sin_drv(sin_drv), .cos_drv(cos_drv)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input int c);
        @(negedge clk);
        code = 10'(c);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    function automatic int model(input int c, input bit want_sin);
        real th, s, k, m, v;
        th = c * 2.0 * 3.14159265358979 / 1024.0;
        s = $sin(th);
        k = $cos(th);
        m = (s < 0 ? -s : s) > (k < 0 ? -k : k) ? (s < 0 ? -s : s) : (k < 0 ? -k : k);
        v = 255.0 * (want_sin ? s : k) / m;
        return (v >= 0) ? int'($floor(v + 0.5)) : -int'($floor(-v + 0.5));
    endfunction

    function automatic int iabs(input int v);
        return v < 0 ? -v : v;
    endfunction

    task automatic t_reset;
        check(sin_drv == 0, "R1 sin after reset", sin_drv, 0);
        check(cos_drv == 0, "R1 cos after reset", cos_drv, 0);
    endtask

    task automatic t_cardinal;
        int exp_s [4] = '{0, 255, 0, -255};
        int exp_c [4] = '{255, 0, -255, 0};
        for (int q = 0; q < 4; q++) begin
            apply(q * 256);
            check(sin_drv == exp_s[q], "R4 cardinal sin", sin_drv, exp_s[q]);
            check(cos_drv == exp_c[q], "R4 cardinal cos", cos_drv, exp_c[q]);
        end
    endtask

    task automatic t_diagonal;
        int sg_s [4] = '{1, 1, -1, -1};
        int sg_c [4] = '{1, -1, -1, 1};
        for (int q = 0; q < 4; q++) begin
            apply(128 + q * 256);
            check(iabs(sin_drv) >= 248 && (sin_drv > 0) == (sg_s[q] > 0), "R5 diagonal sin", sin_drv, sg_s[q] * 255);
            check(iabs(cos_drv) >= 248 && (cos_drv > 0) == (sg_c[q] > 0), "R5 diagonal cos", cos_drv, sg_c[q] * 255);
        end
    endtask

    task automatic t_octants;
        for (int o = 0; o < 8; o++) begin
            int es, ec;
            apply(o * 128 + 64);
            es = model(o * 128 + 64, 1'b1);
            ec = model(o * 128 + 64, 1'b0);
            if (iabs(es) == 255)
                check(sin_drv == es, "R3 held sine coil", sin_drv, es);
            else
                check(cos_drv == ec, "R3 held cosine coil", cos_drv, ec);
        end
    endtask

    task automatic t_hold;
        apply(256);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            code = 10'(512 + i * 100);
        end
        @(negedge clk);
        check(sin_drv == 255, "R2 hold sin", sin_drv, 255);
        check(cos_drv == 0, "R2 hold cos", cos_drv, 0);
    endtask

    task automatic t_sweep;
        int prev = -1;
        for (int c = 0; c < 1024; c++) begin
            int es, ec;
            apply(c);
            es = model(c, 1'b1);
            ec = model(c, 1'b0);
            check(iabs(sin_drv - es) <= 4 && iabs(cos_drv - ec) <= 4, "R6 sweep", c * 1000 + sin_drv, c * 1000 + es);
            check(sin_drv <= 255 && sin_drv >= -255 &&
                  (iabs(sin_drv) == 255 || iabs(cos_drv) == 255), "R8 range/full", sin_drv, cos_drv);
            if (c < 128) begin
                check(int'(sin_drv) >= prev, "R7 monotonic", sin_drv, prev);
                prev = sin_drv;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cardinal();
        t_diagonal();
        t_octants();
        t_hold();
        t_sweep();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule